// File: doc/BRIEF.md
# Register Rename Stage with Zeroing-Idiom Detection

This block is the rename step of a single-issue out-of-order core. Each cycle it can take one decoded instruction. That instruction names up to two source registers, an optional general destination and a flag-write bit, plus a two-bit operation class. In the same cycle the block answers with the physical tag behind each source and whether the consumer must wait on it. For each written register it also returns a freshly allocated physical tag and the tag the register was mapped to before. The previous tag must be handed back on the commit port once the instruction retires. The condition flags are renamed exactly like a seventeenth architectural register.

A speculative map table holds the current architectural-to-physical binding. A circular queue holds the unused tags. The block detects an XOR or SUB whose two sources are the same register. Such an instruction gets a new destination as usual, but it reports no source dependency and marks its new tag as ready with value zero. An immediate move likewise carries no source dependency. When the queue cannot supply every tag an instruction needs, the stage drops its ready output and leaves all state alone. Tags released on the commit port join the tail of the queue and become usable from the next cycle.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register i (0..15) maps to tag i, the flags (source index 16) map to tag 16, and allocation hands out tags 17, 18, 19, ... in that order.
- R2: An accepted instruction with a destination receives the tag at the head of the free queue as `out_dst_tag`, and `out_dst_prev` reports the register's mapping before the write. Later reads of that register return the new tag.
- R3: An accepted instruction that writes neither a register nor the flags allocates nothing. The next allocation gets the same tag it would have received without that instruction.
- R4: A source that names the instruction's own destination reads the mapping from before this instruction.
- R5: Operation class 1 (XOR) or 2 (SUB) with both sources enabled and equal is a zeroing idiom. It clears both dependency outputs, still allocates a destination, and raises `out_dst_zero`. With different sources, both dependencies stay set and `out_dst_zero` stays low.
- R6: Operation class 3 (immediate move) clears all source dependencies and allocates only its destination, with `out_dst_zero` low.
- R7: When `in_flag_wr` is set, the flags receive their own new tag (`out_flag_tag`), with the old one on `out_flag_prev`. When a general destination is also written, that destination takes the head tag and the flags take the next one.
- R8: When fewer free tags exist than the instruction needs, `in_ready` and `out_valid` are low, and neither the map table nor the free queue changes.
- R9: Tags presented on the commit port enter the tail of the free queue: the destination-side tag first, then the flag-side tag. They are allocated after all tags already queued.
- R10: A tag freed on the commit port cannot satisfy an allocation in the same cycle. It counts only from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Enough free tags to accept the instruction |
| in_kind | input | 2 | Class: 0 other, 1 XOR, 2 SUB, 3 immediate move |
| in_src0_en | input | 1 | Source 0 used |
| in_src0_reg | input | 5 | Source 0 index (16 = flags) |
| in_src1_en | input | 1 | Source 1 used |
| in_src1_reg | input | 5 | Source 1 index (16 = flags) |
| in_dst_en | input | 1 | General destination written |
| in_dst_reg | input | 4 | Destination index |
| in_flag_wr | input | 1 | Instruction writes flags |
| out_valid | output | 1 | Instruction accepted this cycle |
| out_src0_tag | output | 7 | Physical tag of source 0 |
| out_src0_dep | output | 1 | Source 0 is a true dependency |
| out_src1_tag | output | 7 | Physical tag of source 1 |
| out_src1_dep | output | 1 | Source 1 is a true dependency |
| out_dst_tag | output | 7 | New destination tag |
| out_dst_prev | output | 7 | Destination's previous tag |
| out_dst_zero | output | 1 | New destination is ready with value zero |
| out_flag_tag | output | 7 | New flags tag |
| out_flag_prev | output | 7 | Flags' previous tag |
| cm_dst_en | input | 1 | Release a destination-side tag |
| cm_dst_tag | input | 7 | Tag released |
| cm_flag_en | input | 1 | Release a flag-side tag |
| cm_flag_tag | input | 7 | Tag released |

## Verification
The assertions rely on several properties of the inputs:
- Source indexes never exceed 16.
- The commit port returns only tags that earlier left the block as a previous mapping.
- Each returned tag comes back once, in program order.

Under those conditions the free-queue count can never exceed its capacity. The bench keeps to them as follows:
- It reads only registers 0 to 16.
- It commits only the two previous tags of the first instruction in its vector table, and only once.
- It makes those releases while the queue is empty, so the first release in program order is the one observed.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    OPK_OTHER = 2'd0,
    OPK_XOR   = 2'd1,
    OPK_SUB   = 2'd2,
    OPK_MOVI  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/rn_idiom.sv
module rn_idiom
  import rn_pkg::*;
#(
  parameter int AW = 5
) (
  input  op_kind_e        kind,
  input  logic            s0_en,
  input  logic [AW-1:0]   s0_reg,
  input  logic            s1_en,
  input  logic [AW-1:0]   s1_reg,
  output logic            s0_dep,
  output logic            s1_dep,
  output logic            zero_pat
);
  logic self_op;
  logic no_src;

  always_comb begin
    self_op  = (kind == OPK_XOR) || (kind == OPK_SUB);
    zero_pat = self_op && s0_en && s1_en && (s0_reg == s1_reg);
    no_src   = zero_pat || (kind == OPK_MOVI);
    s0_dep   = s0_en && !no_src;
    s1_dep   = s1_en && !no_src;
  end
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
  parameter int NUM_MAP = 17,
  parameter int TW      = 7,
  parameter int AW      = 5,
  localparam int FLAG_IDX = NUM_MAP - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd0_idx,
  input  logic [AW-1:0] rd1_idx,
  input  logic [AW-1:0] rdd_idx,
  output logic [TW-1:0] rd0_tag,
  output logic [TW-1:0] rd1_tag,
  output logic [TW-1:0] rdd_tag,
  output logic [TW-1:0] rdf_tag,
  input  logic          wr_dst_en,
  input  logic [AW-1:0] wr_dst_idx,
  input  logic [TW-1:0] wr_dst_tag,
  input  logic          wr_flag_en,
  input  logic [TW-1:0] wr_flag_tag
);
  logic [TW-1:0] map_q [NUM_MAP];
  logic [TW-1:0] map_d [NUM_MAP];

  function automatic logic [TW-1:0] lookup(input logic [AW-1:0] idx);
    logic [TW-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_MAP; i++) begin
      if (idx == AW'(i)) r = map_q[i];
    end
    return r;
  endfunction

  always_comb begin
    rd0_tag = lookup(rd0_idx);
    rd1_tag = lookup(rd1_idx);
    rdd_tag = lookup(rdd_idx);
    rdf_tag = map_q[FLAG_IDX];
  end

  always_comb begin
    for (int i = 0; i < NUM_MAP; i++) begin
      map_d[i] = map_q[i];
      if (wr_dst_en && (wr_dst_idx == AW'(i))) map_d[i] = wr_dst_tag;
    end
    if (wr_flag_en) map_d[FLAG_IDX] = wr_flag_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MAP; i++) map_q[i] <= TW'(i);
    end else if (wr_dst_en || wr_flag_en) begin
      for (int i = 0; i < NUM_MAP; i++) map_q[i] <= map_d[i];
    end
  end

  // R2: a written mapping is the one read afterwards
  a_r2_map_holds_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dst_en |=> map_q[$past(wr_dst_idx)] == $past(wr_dst_tag));

  // R7: the flags entry takes the flag tag
  a_r7_flag_holds_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag_en |=> rdf_tag == $past(wr_flag_tag));

  // R8: without writes the flags mapping stays put
  a_r8_map_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag_en |=> $stable(rdf_tag));
endmodule

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int NUM_PHYS = 128,
  parameter int NUM_RESV = 17,
  parameter int TW       = 7,
  localparam int CAP     = NUM_PHYS - NUM_RESV,
  localparam int CW      = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pop_cnt,
  input  logic          push_a_en,
  input  logic [TW-1:0] push_a_tag,
  input  logic          push_b_en,
  input  logic [TW-1:0] push_b_tag,
  output logic [TW-1:0] head0_tag,
  output logic [TW-1:0] head1_tag,
  output logic [CW-1:0] avail
);
  logic [TW-1:0] slot_q [NUM_PHYS];
  logic [TW-1:0] head_q, head_d, tail_q, tail_d, tail_b;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    push_cnt;

  function automatic logic [TW-1:0] bump(input logic [TW-1:0] p);
    return (p == TW'(NUM_PHYS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    push_cnt  = {1'b0, push_a_en} + {1'b0, push_b_en};
    tail_b    = push_a_en ? bump(tail_q) : tail_q;
    head0_tag = slot_q[head_q];
    head1_tag = slot_q[bump(head_q)];
    avail     = cnt_q;
    head_d    = head_q;
    if (pop_cnt == 2'd1) head_d = bump(head_q);
    else if (pop_cnt == 2'd2) head_d = bump(bump(head_q));
    tail_d    = tail_q;
    if (push_cnt == 2'd1) tail_d = bump(tail_q);
    else if (push_cnt == 2'd2) tail_d = bump(bump(tail_q));
    cnt_d     = cnt_q + CW'(push_cnt) - CW'(pop_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= TW'(CAP % NUM_PHYS);
      cnt_q  <= CW'(CAP);
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++)
        slot_q[i] <= (i < CAP) ? TW'(i + NUM_RESV) : '0;
    end else begin
      if (push_a_en) slot_q[tail_q] <= push_a_tag;
      if (push_b_en) slot_q[tail_b] <= push_b_tag;
    end
  end

  // R8: never hand out more tags than are queued
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_cnt) <= cnt_q);

  // R9: legal releases never overfill the queue
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CAP));
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer
  import rn_pkg::*;
#(
  parameter int NUM_GPR  = 16,
  parameter int NUM_PHYS = 128,
  localparam int NUM_MAP = NUM_GPR + 1,
  localparam int AW      = $clog2(NUM_MAP),
  localparam int GW      = $clog2(NUM_GPR),
  localparam int TW      = $clog2(NUM_PHYS),
  localparam int CW      = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_kind,
  input  logic          in_src0_en,
  input  logic [AW-1:0] in_src0_reg,
  input  logic          in_src1_en,
  input  logic [AW-1:0] in_src1_reg,
  input  logic          in_dst_en,
  input  logic [GW-1:0] in_dst_reg,
  input  logic          in_flag_wr,
  output logic          out_valid,
  output logic [TW-1:0] out_src0_tag,
  output logic          out_src0_dep,
  output logic [TW-1:0] out_src1_tag,
  output logic          out_src1_dep,
  output logic [TW-1:0] out_dst_tag,
  output logic [TW-1:0] out_dst_prev,
  output logic          out_dst_zero,
  output logic [TW-1:0] out_flag_tag,
  output logic [TW-1:0] out_flag_prev,
  input  logic          cm_dst_en,
  input  logic [TW-1:0] cm_dst_tag,
  input  logic          cm_flag_en,
  input  logic [TW-1:0] cm_flag_tag
);
  logic [1:0]    need;
  logic          fire;
  logic [1:0]    pop_cnt;
  logic [TW-1:0] head0, head1;
  logic [CW-1:0] avail;
  logic          zero_pat;
  logic [AW-1:0] dst_idx;

  assign dst_idx = AW'(in_dst_reg);

  rn_idiom #(.AW(AW)) u_idiom (
    .kind    (op_kind_e'(in_kind)),
    .s0_en   (in_src0_en),
    .s0_reg  (in_src0_reg),
    .s1_en   (in_src1_en),
    .s1_reg  (in_src1_reg),
    .s0_dep  (out_src0_dep),
    .s1_dep  (out_src1_dep),
    .zero_pat(zero_pat)
  );

  always_comb begin
    need         = {1'b0, in_dst_en} + {1'b0, in_flag_wr};
    in_ready     = (avail >= CW'(need));
    fire         = in_valid && in_ready;
    pop_cnt      = fire ? need : 2'd0;
    out_valid    = fire;
    out_dst_tag  = head0;
    out_flag_tag = in_dst_en ? head1 : head0;
    out_dst_zero = fire && in_dst_en && zero_pat;
  end

  rn_maptable #(.NUM_MAP(NUM_MAP), .TW(TW), .AW(AW)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd0_idx    (in_src0_reg),
    .rd1_idx    (in_src1_reg),
    .rdd_idx    (dst_idx),
    .rd0_tag    (out_src0_tag),
    .rd1_tag    (out_src1_tag),
    .rdd_tag    (out_dst_prev),
    .rdf_tag    (out_flag_prev),
    .wr_dst_en  (fire && in_dst_en),
    .wr_dst_idx (dst_idx),
    .wr_dst_tag (out_dst_tag),
    .wr_flag_en (fire && in_flag_wr),
    .wr_flag_tag(out_flag_tag)
  );

  rn_freelist #(.NUM_PHYS(NUM_PHYS), .NUM_RESV(NUM_MAP), .TW(TW)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_cnt   (pop_cnt),
    .push_a_en (cm_dst_en),
    .push_a_tag(cm_dst_tag),
    .push_b_en (cm_flag_en),
    .push_b_tag(cm_flag_tag),
    .head0_tag (head0),
    .head1_tag (head1),
    .avail     (avail)
  );

  // R5: a zeroing result never waits on a source
  a_r5_zero_no_dep: assert property (@(posedge clk) disable iff (!rst_n)
    out_dst_zero |-> !out_src0_dep && !out_src1_dep);

  // R7: dual allocation yields two distinct tags
  a_r7_distinct_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_dst_en && in_flag_wr) |-> out_dst_tag != out_flag_tag);

  // R2: a fresh tag is never the one being replaced
  a_r2_fresh_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_dst_en) |-> out_dst_tag != out_dst_prev);
endmodule

// File: tb/reg_renamer_bench.sv
module reg_renamer_bench;
  timeunit 1ns;
  timeprecision 100ps;

  typedef struct packed {
    logic [1:0] kind;
    logic s0u; logic [4:0] s0;
    logic s1u; logic [4:0] s1;
    logic du;  logic [3:0] d;
    logic fw;
    logic [6:0] es0; logic ed0;
    logic [6:0] es1; logic ed1;
    logic [6:0] edt; logic [6:0] edo; logic ez;
    logic [6:0] eft; logic [6:0] efo;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{2'd0,1'b1,5'd2, 1'b1,5'd3, 1'b1,4'd1,1'b1, 7'd2,1'b1, 7'd3,1'b1, 7'd17,7'd1,1'b0, 7'd18,7'd16},
    '{2'd0,1'b1,5'd1, 1'b1,5'd5, 1'b1,4'd4,1'b0, 7'd17,1'b1,7'd5,1'b1, 7'd19,7'd4,1'b0, 7'd0,7'd0},
    '{2'd1,1'b1,5'd1, 1'b1,5'd1, 1'b1,4'd1,1'b1, 7'd17,1'b0,7'd17,1'b0,7'd20,7'd17,1'b1,7'd21,7'd18},
    '{2'd2,1'b1,5'd6, 1'b1,5'd7, 1'b1,4'd6,1'b0, 7'd6,1'b1, 7'd7,1'b1, 7'd22,7'd6,1'b0, 7'd0,7'd0},
    '{2'd3,1'b1,5'd2, 1'b0,5'd0, 1'b1,4'd2,1'b0, 7'd2,1'b0, 7'd0,1'b0, 7'd23,7'd2,1'b0, 7'd0,7'd0},
    '{2'd0,1'b1,5'd16,1'b1,5'd6, 1'b0,4'd0,1'b0, 7'd21,1'b1,7'd22,1'b1,7'd0,7'd0,1'b0, 7'd0,7'd0},
    '{2'd0,1'b1,5'd6, 1'b1,5'd2, 1'b1,4'd6,1'b0, 7'd22,1'b1,7'd23,1'b1,7'd24,7'd22,1'b0,7'd0,7'd0},
    '{2'd2,1'b1,5'd9, 1'b1,5'd9, 1'b1,4'd9,1'b0, 7'd9,1'b0, 7'd9,1'b0, 7'd25,7'd9,1'b1, 7'd0,7'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_kind = '0;
  logic in_src0_en = 1'b0, in_src1_en = 1'b0, in_dst_en = 1'b0, in_flag_wr = 1'b0;
  logic [4:0] in_src0_reg = '0, in_src1_reg = '0;
  logic [3:0] in_dst_reg = '0;
  logic out_valid, out_src0_dep, out_src1_dep, out_dst_zero;
  logic [6:0] out_src0_tag, out_src1_tag, out_dst_tag, out_dst_prev, out_flag_tag, out_flag_prev;
  logic cm_dst_en = 1'b0, cm_flag_en = 1'b0;
  logic [6:0] cm_dst_tag = '0, cm_flag_tag = '0;

  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  reg_renamer u_reg_renamer (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] k, input logic a, input logic [4:0] ai,
                     input logic b, input logic [4:0] bi, input logic d,
                     input logic [3:0] di, input logic f);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k;
    in_src0_en = a; in_src0_reg = ai; in_src1_en = b; in_src1_reg = bi;
    in_dst_en = d; in_dst_reg = di; in_flag_wr = f;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    // R1: reset mapping, pure read
    put(2'd0, 1'b1, 5'd5, 1'b1, 5'd15, 1'b0, 4'd0, 1'b0);
    check("R1 ready", in_ready, 1);
    check("R1 src0", out_src0_tag, 5);
    check("R1 src1", out_src1_tag, 15);

    for (int v = 0; v < NV; v++) begin
      put(TBL[v].kind, TBL[v].s0u, TBL[v].s0, TBL[v].s1u, TBL[v].s1,
          TBL[v].du, TBL[v].d, TBL[v].fw);
      check("R2 out_valid", out_valid, 1);
      if (TBL[v].s0u) begin
        check("R4 src0 tag", out_src0_tag, TBL[v].es0);
        check("R5 R6 src0 dep", out_src0_dep, TBL[v].ed0);
      end
      if (TBL[v].s1u) begin
        check("R4 src1 tag", out_src1_tag, TBL[v].es1);
        check("R5 src1 dep", out_src1_dep, TBL[v].ed1);
      end
      if (TBL[v].du) begin
        check("R1 R2 R3 dst tag", out_dst_tag, TBL[v].edt);
        check("R2 dst prev", out_dst_prev, TBL[v].edo);
        check("R5 R6 zero", out_dst_zero, TBL[v].ez);
      end
      if (TBL[v].fw) begin
        check("R7 flag tag", out_flag_tag, TBL[v].eft);
        check("R7 flag prev", out_flag_prev, TBL[v].efo);
      end
    end

    // drain to one free tag: r0 takes tags 26..126
    for (int k = 0; k < 101; k++) put(2'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 4'd0, 1'b0);

    // R8: need two, one available
    put(2'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 4'd3, 1'b1);
    check("R8 ready low", in_ready, 0);
    check("R8 no valid", out_valid, 0);
    @(negedge clk); #1;
    check("R8 still held", in_ready, 0);
    put(2'd0, 1'b1, 5'd3, 1'b1, 5'd16, 1'b0, 4'd0, 1'b0);
    check("R8 r3 unchanged", out_src0_tag, 3);
    check("R8 flags unchanged", out_src1_tag, 21);
    put(2'd0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b1, 4'd0, 1'b0);
    check("R8 last tag", out_dst_tag, 127);
    check("R2 prev r0", out_dst_prev, 126);

    // R10: queue empty, release in the same cycle
    put(2'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 4'd5, 1'b0);
    cm_dst_en = 1'b1; cm_dst_tag = 7'd1; cm_flag_en = 1'b1; cm_flag_tag = 7'd16;
    #0.5;
    check("R10 same cycle", in_ready, 0);
    @(negedge clk);
    cm_dst_en = 1'b0; cm_flag_en = 1'b0;
    #1;
    check("R10 next cycle", in_ready, 1);
    check("R9 first freed", out_dst_tag, 1);
    check("R2 prev r5", out_dst_prev, 5);
    put(2'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 4'd5, 1'b0);
    check("R9 second freed", out_dst_tag, 16);
    put(2'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 4'd5, 1'b0);
    check("R8 empty single", in_ready, 0);

    @(negedge clk);
    in_valid = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule